// File: doc/BRIEF.md
# Serial Frame Parity Stripper and Field Extractor

This block takes an already demodulated serial bitstream, one bit per clock cycle in which the strobe input is high, and finds credential frames in it. A frame has 96 bits. It opens with the 8-bit start pattern `00000001`, and 22 four-bit groups follow. In each group, three data bits come first and an odd-parity bit comes last. The block checks every group's parity as the bits arrive and drops a frame at the first bad group. It removes the parity bits to form a 66-bit payload and decodes that payload: a format length in the leading byte, a facility code and a card number.

When a frame is good, the block updates the raw 96-bit frame, the payload and the decoded fields, and raises a one-cycle valid pulse. These outputs then hold until the next good frame. Bits that arrive while the strobe is low are ignored. All state resets synchronously.

Top module: `fsk_frame_strip`

## Requirements
- R1: A frame starts only when the last 8 strobed bits equal `00000001` (earliest bit first). All 8 of these bits must arrive after reset or after the search last restarted, so a lone `1` right after a restart never starts a frame.
- R2: The 88 bits after the start pattern are 22 groups, each of three data bits followed by one parity bit. A group passes when its four bits hold an odd number of ones. A frame is accepted only if all 22 groups pass.
- R3: The block abandons a frame at the strobe that carries its first failing parity bit. No valid pulse follows, and all outputs keep their previous values. The search for the start pattern restarts with the next strobed bit.
- R4: `rawFrame` holds the 96 bits of the accepted frame, with the earliest bit at bit 95. It splits into three 32-bit words: [95:64], [63:32] and [31:0].
- R5: `payload` holds the 66 data bits in arrival order, with the first data bit at bit 65 and the parity bits removed.
- R6: `fmtLen` equals payload bits [65:58], which are payload positions 0 to 7 counted from the first data bit.
- R7: When `fmtLen` is 26, `facility` comes from payload positions 9 to 16 (`payload[56:49]`). `cardNum` comes from positions 17 to 32 (`payload[48:33]`). Position 8 is a parity bit and is not decoded.
- R8: When `fmtLen` is any other value from 17 to 59, `cardNum` is the 16 bits that start at payload position `fmtLen - 9`, and `facility` is 0. When `fmtLen` is below 17 or above 59, both `cardNum` and `facility` are 0.
- R9: `frameValid` is high for exactly one cycle: the cycle after the clock edge that samples the final parity bit of an accepted frame. All data outputs change in that same cycle and otherwise hold.
- R10: `bitIn` has no effect in any cycle in which `bitValid` is low.
- R11: Synchronous reset clears every output to 0 and restarts the search with an empty history.
- R12: After an accepted frame the search restarts with an empty history, so a following frame is found only from 8 fresh bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitIn | input | 1 | Demodulated serial bit |
| bitValid | input | 1 | Strobe: `bitIn` is sampled when high |
| frameValid | output | 1 | One-cycle pulse for an accepted frame |
| rawFrame | output | 96 | Accepted frame with parity bits, earliest bit at MSB |
| payload | output | 66 | Data bits with parity removed, first bit at MSB |
| fmtLen | output | 8 | Format length field |
| facility | output | 8 | Facility code (26-bit format only) |
| cardNum | output | 16 | Card number |

## Verification
The bench uses the default parameters: an 8-bit start pattern, 22 groups of three data bits, an 8-bit length field, an 8-bit facility field and a 16-bit card field. Because the length field is 8 bits wide, the bench can send a frame for every one of the 256 length codes. That covers the 26-bit format, both edges of the card-number window (16/17 and 59/60) and every code outside it. With 22 groups, the bench can corrupt each group's parity bit in turn and then check that the very next start pattern is found. Strobe gaps carry toggling data, which exercises the rule that unstrobed bits are ignored.

// File: rtl/fsk_frame_pkg.sv
package fsk_frame_pkg;

  typedef enum logic {
    ST_HUNT,
    ST_CAPTURE
  } ctrlState_t;

  typedef struct packed {
    logic take;        // a strobed bit enters the raw history
    logic dataShift;   // the bit is a data bit of the current group
    logic parityStep;  // the bit is the parity bit of the current group
    logic commit;      // last parity bit of a good frame
  } ctrlStrobe_t;

endpackage

// File: rtl/fsk_frame_fields.sv
module fsk_frame_fields #(
  parameter int PAY_LEN = 66,
  parameter int LEN_W   = 8,
  parameter int FAC_W   = 8,
  parameter int CARD_W  = 16,
  parameter int STD_LEN = 26
) (
  input  logic [PAY_LEN-1:0] payIn,
  output logic [LEN_W-1:0]   lenOut,
  output logic [FAC_W-1:0]   facOut,
  output logic [CARD_W-1:0]  cardOut
);
  // card position in the standard format; the general offset reuses it
  localparam int CARD_BASE = LEN_W + 1 + FAC_W;
  localparam int LEN_MIN   = CARD_BASE;
  localparam int LEN_MAX   = PAY_LEN - CARD_W + CARD_BASE - LEN_W;
  localparam int FAC_TOP   = PAY_LEN - LEN_W - 2;

  logic [LEN_W-1:0] cardOff;
  logic             cardInRange;
  logic             isStd;

  always_comb begin
    lenOut      = payIn[PAY_LEN-1 -: LEN_W];
    isStd       = (lenOut == LEN_W'(STD_LEN));
    cardInRange = (lenOut >= LEN_W'(LEN_MIN)) && (lenOut <= LEN_W'(LEN_MAX));
    cardOff     = lenOut - LEN_W'(CARD_BASE - LEN_W);
    facOut      = isStd ? payIn[FAC_TOP -: FAC_W] : '0;
    if (cardInRange)
      cardOut = CARD_W'(payIn >> (LEN_W'(PAY_LEN - CARD_W) - cardOff));
    else
      cardOut = '0;
  end

endmodule

// File: rtl/fsk_frame_ctrl.sv
module fsk_frame_ctrl
  import fsk_frame_pkg::*;
#(
  parameter int PRE_LEN        = 8,
  parameter int GROUPS         = 22,
  parameter int DATA_PER_GROUP = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bitValid,
  input  logic        preambleHit,
  input  logic        parityGood,
  output ctrlStrobe_t strobe
);
  localparam int FILL_W  = (PRE_LEN > 2) ? $clog2(PRE_LEN) : 1;
  localparam int PHASE_W = $clog2(DATA_PER_GROUP + 1);
  localparam int GRP_W   = (GROUPS > 2) ? $clog2(GROUPS) : 1;
  localparam logic [FILL_W-1:0]  FILL_LAST = FILL_W'(PRE_LEN - 1);
  localparam logic [PHASE_W-1:0] PAR_PHASE = PHASE_W'(DATA_PER_GROUP);
  localparam logic [GRP_W-1:0]   GRP_LAST  = GRP_W'(GROUPS - 1);

  ctrlState_t         state, stateNxt;
  logic [FILL_W-1:0]  fillCnt, fillNxt;
  logic [PHASE_W-1:0] phase, phaseNxt;
  logic [GRP_W-1:0]   grpIdx, grpNxt;

  always_comb begin
    strobe      = '0;
    strobe.take = bitValid;
    stateNxt    = state;
    fillNxt     = fillCnt;
    phaseNxt    = phase;
    grpNxt      = grpIdx;
    if (bitValid) begin
      case (state)
        ST_HUNT: begin
          if (fillCnt == FILL_LAST && preambleHit) begin
            stateNxt = ST_CAPTURE;
            phaseNxt = '0;
            grpNxt   = '0;
          end else if (fillCnt != FILL_LAST) begin
            fillNxt = fillCnt + 1'b1;
          end
        end
        ST_CAPTURE: begin
          if (phase != PAR_PHASE) begin
            strobe.dataShift = 1'b1;
            phaseNxt         = phase + 1'b1;
          end else begin
            strobe.parityStep = 1'b1;
            phaseNxt          = '0;
            if (!parityGood) begin
              stateNxt = ST_HUNT;
              fillNxt  = '0;
            end else if (grpIdx == GRP_LAST) begin
              strobe.commit = 1'b1;
              stateNxt      = ST_HUNT;
              fillNxt       = '0;
            end else begin
              grpNxt = grpIdx + 1'b1;
            end
          end
        end
        default: stateNxt = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HUNT;
      fillCnt <= '0;
      phase   <= '0;
      grpIdx  <= '0;
    end else begin
      state   <= stateNxt;
      fillCnt <= fillNxt;
      phase   <= phaseNxt;
      grpIdx  <= grpNxt;
    end
  end

endmodule

// File: rtl/fsk_frame_dp.sv
module fsk_frame_dp
  import fsk_frame_pkg::*;
#(
  parameter int                PRE_LEN        = 8,
  parameter logic [PRE_LEN-1:0] PRE_PATTERN   = 8'h01,
  parameter int                GROUPS         = 22,
  parameter int                DATA_PER_GROUP = 3,
  parameter int                LEN_W          = 8,
  parameter int                FAC_W          = 8,
  parameter int                CARD_W         = 16,
  parameter int                STD_LEN        = 26,
  localparam int               FRAME_LEN      = PRE_LEN + GROUPS * (DATA_PER_GROUP + 1),
  localparam int               PAY_LEN        = GROUPS * DATA_PER_GROUP
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bitIn,
  input  ctrlStrobe_t          strobe,
  output logic                 preambleHit,
  output logic                 parityGood,
  output logic                 frameValid,
  output logic [FRAME_LEN-1:0] rawFrame,
  output logic [PAY_LEN-1:0]   payload,
  output logic [LEN_W-1:0]     fmtLen,
  output logic [FAC_W-1:0]     facility,
  output logic [CARD_W-1:0]    cardNum
);
  // history of the last FRAME_LEN-1 strobed bits; the current bit completes it
  logic [FRAME_LEN-2:0] rawShift;
  logic [PAY_LEN-1:0]   payShift;
  logic                 parityAcc;
  logic [LEN_W-1:0]     lenNew;
  logic [FAC_W-1:0]     facNew;
  logic [CARD_W-1:0]    cardNew;

  assign preambleHit = ({rawShift[PRE_LEN-2:0], bitIn} == PRE_PATTERN);
  assign parityGood  = parityAcc ^ bitIn;

  fsk_frame_fields #(
    .PAY_LEN(PAY_LEN), .LEN_W(LEN_W), .FAC_W(FAC_W),
    .CARD_W(CARD_W), .STD_LEN(STD_LEN)
  ) i_fields (
    .payIn  (payShift),
    .lenOut (lenNew),
    .facOut (facNew),
    .cardOut(cardNew)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rawShift  <= '0;
      payShift  <= '0;
      parityAcc <= 1'b0;
    end else begin
      if (strobe.take)
        rawShift <= {rawShift[FRAME_LEN-3:0], bitIn};
      if (strobe.dataShift) begin
        payShift  <= {payShift[PAY_LEN-2:0], bitIn};
        parityAcc <= parityAcc ^ bitIn;
      end else if (strobe.parityStep) begin
        parityAcc <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frameValid <= 1'b0;
      rawFrame   <= '0;
      payload    <= '0;
      fmtLen     <= '0;
      facility   <= '0;
      cardNum    <= '0;
    end else begin
      frameValid <= strobe.commit;
      if (strobe.commit) begin
        rawFrame <= {rawShift, bitIn};
        payload  <= payShift;
        fmtLen   <= lenNew;
        facility <= facNew;
        cardNum  <= cardNew;
      end
    end
  end

endmodule

// File: rtl/fsk_frame_strip.sv
module fsk_frame_strip
  import fsk_frame_pkg::*;
#(
  parameter int                PRE_LEN        = 8,
  parameter logic [PRE_LEN-1:0] PRE_PATTERN   = 8'h01,
  parameter int                GROUPS         = 22,
  parameter int                DATA_PER_GROUP = 3,
  parameter int                LEN_W          = 8,
  parameter int                FAC_W          = 8,
  parameter int                CARD_W         = 16,
  parameter int                STD_LEN        = 26,
  localparam int               FRAME_LEN      = PRE_LEN + GROUPS * (DATA_PER_GROUP + 1),
  localparam int               PAY_LEN        = GROUPS * DATA_PER_GROUP
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bitIn,
  input  logic                 bitValid,
  output logic                 frameValid,
  output logic [FRAME_LEN-1:0] rawFrame,
  output logic [PAY_LEN-1:0]   payload,
  output logic [LEN_W-1:0]     fmtLen,
  output logic [FAC_W-1:0]     facility,
  output logic [CARD_W-1:0]    cardNum
);
  ctrlStrobe_t strobe;
  logic        preambleHit;
  logic        parityGood;

  fsk_frame_ctrl #(
    .PRE_LEN(PRE_LEN), .GROUPS(GROUPS), .DATA_PER_GROUP(DATA_PER_GROUP)
  ) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .bitValid   (bitValid),
    .preambleHit(preambleHit),
    .parityGood (parityGood),
    .strobe     (strobe)
  );

  fsk_frame_dp #(
    .PRE_LEN(PRE_LEN), .PRE_PATTERN(PRE_PATTERN), .GROUPS(GROUPS),
    .DATA_PER_GROUP(DATA_PER_GROUP), .LEN_W(LEN_W), .FAC_W(FAC_W),
    .CARD_W(CARD_W), .STD_LEN(STD_LEN)
  ) i_dp (
    .clk        (clk),
    .rst        (rst),
    .bitIn      (bitIn),
    .strobe     (strobe),
    .preambleHit(preambleHit),
    .parityGood (parityGood),
    .frameValid (frameValid),
    .rawFrame   (rawFrame),
    .payload    (payload),
    .fmtLen     (fmtLen),
    .facility   (facility),
    .cardNum    (cardNum)
  );

endmodule

// File: rtl/fsk_frame_strip_chk.sv
module fsk_frame_strip_chk #(
  parameter int                PRE_LEN        = 8,
  parameter logic [PRE_LEN-1:0] PRE_PATTERN   = 8'h01,
  parameter int                GROUPS         = 22,
  parameter int                DATA_PER_GROUP = 3,
  parameter int                LEN_W          = 8,
  parameter int                FAC_W          = 8,
  parameter int                CARD_W         = 16,
  parameter int                STD_LEN        = 26,
  localparam int               FRAME_LEN      = PRE_LEN + GROUPS * (DATA_PER_GROUP + 1),
  localparam int               PAY_LEN        = GROUPS * DATA_PER_GROUP
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bitValid,
  input logic                 frameValid,
  input logic [FRAME_LEN-1:0] rawFrame,
  input logic [PAY_LEN-1:0]   payload,
  input logic [LEN_W-1:0]     fmtLen,
  input logic [FAC_W-1:0]     facility,
  input logic [CARD_W-1:0]    cardNum
);
  localparam int GW = DATA_PER_GROUP + 1;

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  function automatic logic allOdd(input logic [FRAME_LEN-1:0] f);
    logic ok = 1'b1;
    for (int g = 0; g < GROUPS; g++)
      ok &= ^f[FRAME_LEN-1-PRE_LEN-g*GW -: GW];
    return ok;
  endfunction

  function automatic logic [PAY_LEN-1:0] stripped(input logic [FRAME_LEN-1:0] f);
    logic [PAY_LEN-1:0] p = '0;
    for (int g = 0; g < GROUPS; g++)
      for (int d = 0; d < DATA_PER_GROUP; d++)
        p[PAY_LEN-1-g*DATA_PER_GROUP-d] = f[FRAME_LEN-1-PRE_LEN-g*GW-d];
    return p;
  endfunction

  // R9: the valid flag never lasts two cycles
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst || !armed)
    frameValid |=> !frameValid);

  // R9: outputs hold whenever no pulse announces a new frame
  a_r9_hold: assert property (@(posedge clk) disable iff (rst || !armed)
    !frameValid |-> ($stable(rawFrame) && $stable(payload) && $stable(fmtLen)
                     && $stable(facility) && $stable(cardNum)));

  // R10: a pulse follows only a cycle with a strobed bit
  a_r10_after_strobe: assert property (@(posedge clk) disable iff (rst || !armed)
    frameValid |-> $past(bitValid));

  // R1: an accepted frame begins with the start pattern
  a_r1_preamble: assert property (@(posedge clk) disable iff (rst || !armed)
    frameValid |-> (rawFrame[FRAME_LEN-1 -: PRE_LEN] == PRE_PATTERN));

  // R2: every group of an accepted frame has odd parity
  a_r2_odd_groups: assert property (@(posedge clk) disable iff (rst || !armed)
    frameValid |-> allOdd(rawFrame));

  // R5: payload is the raw frame with parity bits removed
  a_r5_payload: assert property (@(posedge clk) disable iff (rst || !armed)
    frameValid |-> (payload == stripped(rawFrame)));

  // R6: length field is the leading payload byte
  a_r6_len: assert property (@(posedge clk) disable iff (rst || !armed)
    frameValid |-> (fmtLen == payload[PAY_LEN-1 -: LEN_W]));

  // R8: facility is only decoded for the standard length
  a_r8_fac_zero: assert property (@(posedge clk) disable iff (rst || !armed)
    (frameValid && fmtLen != LEN_W'(STD_LEN)) |-> (facility == '0));

endmodule

bind fsk_frame_strip fsk_frame_strip_chk #(
  .PRE_LEN(PRE_LEN), .PRE_PATTERN(PRE_PATTERN), .GROUPS(GROUPS),
  .DATA_PER_GROUP(DATA_PER_GROUP), .LEN_W(LEN_W), .FAC_W(FAC_W),
  .CARD_W(CARD_W), .STD_LEN(STD_LEN)
) i_chk (
  .clk(clk), .rst(rst), .bitValid(bitValid), .frameValid(frameValid),
  .rawFrame(rawFrame), .payload(payload), .fmtLen(fmtLen),
  .facility(facility), .cardNum(cardNum)
);

// File: tb/test_fsk_frame_strip.sv
module test_fsk_frame_strip;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bitIn = 1'b0;
  logic        bitValid = 1'b0;
  logic        frameValid;
  logic [95:0] rawFrame;
  logic [65:0] payload;
  logic [7:0]  fmtLen;
  logic [7:0]  facility;
  logic [15:0] cardNum;

  int nChecks = 0;
  int nFails  = 0;
  int pulses  = 0;
  logic pulseOnStrobe = 1'b0;
  logic [31:0] seed = 32'h1ACE_B00C;
  logic [95:0] lastRaw = '0;
  logic [65:0] lastPay = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fsk_frame_strip i_fsk_frame_strip (
    .clk(clk), .rst(rst), .bitIn(bitIn), .bitValid(bitValid),
    .frameValid(frameValid), .rawFrame(rawFrame), .payload(payload),
    .fmtLen(fmtLen), .facility(facility), .cardNum(cardNum)
  );

  task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [95:0] buildFrame(input logic [65:0] pay);
    logic [95:0] f;
    f[95:88] = 8'b0000_0001;
    for (int g = 0; g < 22; g++) begin
      logic [2:0] d = pay[65-3*g -: 3];
      f[87-4*g -: 4] = {d, ~^d};
    end
    return f;
  endfunction

  function automatic logic [7:0] expFac(input logic [65:0] pay);
    return (pay[65:58] == 8'd26) ? pay[56:49] : 8'd0;
  endfunction

  function automatic logic [15:0] expCard(input logic [65:0] pay);
    int len = int'(pay[65:58]);
    logic [15:0] c = '0;
    if (len >= 17 && len <= 59)
      for (int j = 0; j < 16; j++) c[15-j] = pay[65-(len-9)-j];
    return c;
  endfunction

  task automatic putBit(input logic b, input int gap);
    bitIn = b;
    bitValid = 1'b1;
    @(negedge clk);
    pulseOnStrobe = frameValid;
    if (frameValid) pulses++;
    bitValid = 1'b0;
    bitIn = ~b;
    for (int k = 0; k < gap; k++) begin
      @(negedge clk);
      if (frameValid) pulses++;
      bitIn = ~bitIn;
    end
  endtask

  task automatic sendBits(input logic [95:0] f, input int nBits, input logic gapMode);
    for (int i = 0; i < nBits; i++)
      putBit(f[95-i], (gapMode && (i % 7 == 3)) ? 2 : 0);
  endtask

  task automatic goodFrame(input logic [65:0] pay, input int lead, input logic gapMode, input string tag);
    logic [95:0] f = buildFrame(pay);
    pulses = 0;
    for (int i = 0; i < lead; i++) putBit(1'b0, 0);
    sendBits(f, 96, gapMode);
    chk(pulses == 1 && pulseOnStrobe, {"R9 pulse after last bit ", tag}, 128'(pulses), 128'(1));
    chk(rawFrame == f, {"R4 raw frame ", tag}, 128'(rawFrame), 128'(f));
    chk(payload == pay, {"R5 payload ", tag}, 128'(payload), 128'(pay));
    chk(fmtLen == pay[65:58], {"R6 length ", tag}, 128'(fmtLen), 128'(pay[65:58]));
    chk(facility == expFac(pay), {"R7 facility ", tag}, 128'(facility), 128'(expFac(pay)));
    chk(cardNum == expCard(pay), {"R8 card ", tag}, 128'(cardNum), 128'(expCard(pay)));
    @(negedge clk);
    chk(frameValid == 1'b0, {"R9 single cycle ", tag}, 128'(frameValid), 128'(0));
    lastRaw = f;
    lastPay = pay;
  endtask

  function automatic logic [65:0] randPay(input logic [7:0] len, inout logic [31:0] s);
    logic [65:0] p;
    s = nextRand(s); p[31:0]  = s;
    s = nextRand(s); p[57:32] = s[25:0];
    p[65:58] = len;
    return p;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(frameValid == 1'b0 && rawFrame == '0 && payload == '0, "R11 reset outputs", 128'(rawFrame), 128'(0));
    chk(fmtLen == '0 && facility == '0 && cardNum == '0, "R11 reset fields", 128'({fmtLen, facility, cardNum}), 128'(0));
    rst = 1'b0;
    @(negedge clk);

    // R1: a lone one right after reset must not start a frame
    putBit(1'b1, 0);
    goodFrame(randPay(8'd26, seed), 0, 1'b0, "R1 lone one after reset");

    // sweep every length code; R10 via gaps carrying toggling data
    for (int len = 0; len < 256; len++)
      goodFrame(randPay(8'(len), seed), len % 3, (len % 4 == 1), "sweep");
    for (int n = 0; n < 8; n++)
      goodFrame(randPay(8'd26, seed), 1, n[0], "R7 std format");

    // R12: lone one after a good frame, then a frame back to back
    putBit(1'b1, 0);
    goodFrame(randPay(8'd40, seed), 0, 1'b0, "R12 restart after frame");
    goodFrame(randPay(8'd26, seed), 0, 1'b0, "R12 back to back");

    // R3: corrupt each group in turn, then a frame right after the failure
    for (int g = 0; g < 22; g++) begin
      logic [95:0] f = buildFrame(randPay(8'(20 + g), seed));
      f[87-4*g-3] = ~f[87-4*g-3];
      pulses = 0;
      putBit(1'b0, 0);
      putBit(1'b0, 0);
      sendBits(f, 8 + 4*g + 4, 1'b1);
      chk(pulses == 0, "R3 no pulse on parity error", 128'(pulses), 128'(0));
      chk(rawFrame == lastRaw && payload == lastPay, "R3 outputs held", 128'(rawFrame), 128'(lastRaw));
      goodFrame(randPay(8'(30 + g), seed), 0, 1'b0, "R3 restart after error");
    end

    // R11: reset in the middle of a frame
    begin
      logic [95:0] f = buildFrame(randPay(8'd26, seed));
      sendBits(f, 40, 1'b0);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(rawFrame == '0 && payload == '0 && cardNum == '0 && frameValid == 1'b0,
          "R11 mid-frame reset", 128'(rawFrame), 128'(0));
      rst = 1'b0;
      @(negedge clk);
      goodFrame(randPay(8'd55, seed), 2, 1'b1, "R11 after reset");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL R9 watchdog: actual hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule